// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the power state of a chip as one of seven modes: two active modes (normal run and low-power run), two wait modes, and three stop modes of growing depth. Software asks for a wait or stop mode with a one-cycle request strobe. It enters and leaves low-power run through a level request bit. The block moves only along legal transitions. It leaves the wait and stop modes on interrupts or on an external active-low reset/IRQ pin. For every mode it drives a regulator control code: full regulation, standby, or partial power-off.

When the debug-enable input is high, every low-power mode that is asked for is replaced by its fully regulated equivalent. The regulator control is then forced to full regulation. The status outputs report the regulator state that is actually in force, not the mode that software requested. The deepest stop mode can only be left through the external pin. That pin is sampled through a synchroniser. A genuine exit from the deepest stop mode sets a sticky recovery flag, which software clears with a write strobe. There is no data stream through the block, so every pin is a plain control or status signal with no back-pressure.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, the mode is Run (code 0), the regulator code is full (0), the standby status is 0 and the recovery flag is 0.
- R2: Mode codes are Run 0, Wait 1, Stop4 2, LPrun 3, LPwait 4, Stop3 5, Stop2 6. The regulator code is 0 (full) in Run, Wait and Stop4, 1 (standby) in LPrun, LPwait and Stop3, and 2 (partial off) in Stop2. The standby status is 1 exactly when the regulator code is 1.
- R3: A request strobe is taken at the clock edge. From Run, requests for Wait, Stop4 and Stop2 are legal. From LPrun, requests for LPwait and Stop3 are legal. Any other request leaves the mode unchanged. In Run, with no legal request and debug low, a high low-power-regulator request moves the mode to LPrun. In LPrun, with no legal request, a low request bit moves it back to Run.
- R4: Any high interrupt line wakes Wait and Stop4 back to Run, and LPwait and Stop3 back to LPrun, on the next edge.
- R5: In Wait, Stop4, LPwait and Stop3, a low synchronised pin wakes the block only while the IRQ-enable input is 1.
- R6: Stop2 ignores the interrupt lines and leaves only when the pin is low, whatever the IRQ-enable input. The pin passes through a two-stage synchroniser, so a pin driven low before edge 1 changes the mode at edge 3.
- R7: Leaving Stop2 enters Run and sets the recovery flag. The flag stays 1 until a clear strobe. When a set and a clear fall in the same cycle, the set wins.
- R8: While debug is high, a Stop2 request enters Stop4, a Stop3 or LPwait request is never taken, LPrun is left for Run on the next edge, and the low-power-regulator request has no effect. The regulator code reads 0 and the standby status reads 0.
- R9: A wake from a Stop4 that replaced a Stop2 request leaves the recovery flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | 1 | One-cycle strobe requesting entry to req_mode |
| req_mode | input | 3 | Mode code requested (R2 encoding) |
| lpr_req | input | 1 | Low-power regulator request level |
| dbg_en | input | 1 | Debug enable; forces full regulation |
| irq_lines | input | N_IRQ | Interrupt lines, any high wakes wait/stop modes except Stop2 |
| irq_en | input | 1 | Lets the pin wake the non-Stop2 modes |
| wake_pin_n | input | 1 | Asynchronous active-low reset/IRQ pin |
| ppd_clr | input | 1 | Strobe clearing the recovery flag |
| cur_mode | output | 3 | Current mode code |
| reg_ctl | output | 2 | Regulator control code |
| reg_standby | output | 1 | Regulator-in-standby status |
| ppd_flag | output | 1 | Sticky partial-power-down recovery flag |

## Verification
Random traffic mixes requests for all eight codes, including illegal ones, with rare interrupts, pin pulses, toggling of the IRQ-enable and debug inputs and clear strobes. This shows that legality filtering, return to the originating run mode and the debug remapping agree with an independent model on every cycle. Directed sequences pin down the cases random traffic rarely reaches. These are the exact synchroniser latency of the Stop2 exit, Stop2 staying put under interrupts, the pin failing to wake Stop4 while IRQ-enable is 0, a set and a clear in the same cycle, and a debug-forced Stop4 waking without setting the recovery flag.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;
  localparam int RG_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN    = 3'd0,
    M_WAIT   = 3'd1,
    M_STOP4  = 3'd2,
    M_LPRUN  = 3'd3,
    M_LPWAIT = 3'd4,
    M_STOP3  = 3'd5,
    M_STOP2  = 3'd6
  } pmode_t;

  typedef enum logic [RG_W-1:0] {
    RG_FULL = 2'd0,
    RG_STBY = 2'd1,
    RG_PART = 2'd2
  } rgst_t;

  function automatic rgst_t mode_to_reg(input pmode_t m);
    case (m)
      M_LPRUN, M_LPWAIT, M_STOP3: return RG_STBY;
      M_STOP2:                    return RG_PART;
      default:                    return RG_FULL;
    endcase
  endfunction
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_n_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign pin_n_sync = chain[STAGES-1];
endmodule

// File: rtl/lpm_req_filter.sv
module lpm_req_filter
  import lpm_pkg::*;
(
  input  pmode_t                  cur,
  input  logic                    req_go,
  input  logic [MODE_W-1:0]       req_mode,
  input  logic                    dbg_en,
  output logic                    take,
  output pmode_t                  target
);
  logic legal;

  always_comb begin
    legal = 1'b0;
    unique case (cur)
      M_RUN:   legal = (req_mode == M_WAIT) || (req_mode == M_STOP4) ||
                       (req_mode == M_STOP2);
      M_LPRUN: legal = !dbg_en &&
                       ((req_mode == M_LPWAIT) || (req_mode == M_STOP3));
      default: legal = 1'b0;
    endcase
    take = req_go && legal;
  end

  always_comb begin
    target = M_RUN;
    case (req_mode)
      M_WAIT:   target = M_WAIT;
      M_STOP4:  target = M_STOP4;
      M_STOP2:  target = dbg_en ? M_STOP4 : M_STOP2;
      M_LPWAIT: target = M_LPWAIT;
      M_STOP3:  target = M_STOP3;
      default:  target = M_RUN;
    endcase
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  pmode_t           target,
  input  logic             lpr_req,
  input  logic             dbg_en,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             irq_en,
  input  logic             pin_n_sync,
  input  logic             ppd_clr,
  output pmode_t           mode,
  output logic             ppd_flag
);
  pmode_t mode_nx;
  logic   flag_set;
  logic   any_irq;
  logic   pin_wake;
  logic   soft_wake;

  assign any_irq   = |irq_lines;
  assign pin_wake  = !pin_n_sync;
  assign soft_wake = any_irq || (irq_en && pin_wake);

  always_comb begin
    mode_nx  = mode;
    flag_set = 1'b0;
    unique case (mode)
      M_RUN: begin
        if (take)                    mode_nx = target;
        else if (!dbg_en && lpr_req) mode_nx = M_LPRUN;
      end
      M_LPRUN: begin
        if (dbg_en)        mode_nx = M_RUN;
        else if (take)     mode_nx = target;
        else if (!lpr_req) mode_nx = M_RUN;
      end
      M_WAIT, M_STOP4: begin
        if (soft_wake) mode_nx = M_RUN;
      end
      M_LPWAIT, M_STOP3: begin
        if (soft_wake) mode_nx = M_LPRUN;
      end
      M_STOP2: begin
        if (pin_wake) begin
          mode_nx  = M_RUN;
          flag_set = 1'b1;
        end
      end
      default: mode_nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_RUN;
      ppd_flag <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (flag_set)     ppd_flag <= 1'b1;
      else if (ppd_clr) ppd_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_reg_map.sv
module lpm_reg_map
  import lpm_pkg::*;
(
  input  pmode_t mode,
  input  logic   dbg_en,
  output rgst_t  rg,
  output logic   standby
);
  always_comb begin
    rg      = dbg_en ? RG_FULL : mode_to_reg(mode);
    standby = (rg == RG_STBY);
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_go,
  input  logic [2:0]        req_mode,
  input  logic              lpr_req,
  input  logic              dbg_en,
  input  logic [N_IRQ-1:0]  irq_lines,
  input  logic              irq_en,
  input  logic              wake_pin_n,
  input  logic              ppd_clr,
  output logic [2:0]        cur_mode,
  output logic [1:0]        reg_ctl,
  output logic              reg_standby,
  output logic              ppd_flag
);
  pmode_t mode;
  pmode_t target;
  rgst_t  rg;
  logic   take;
  logic   pin_s;

  lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(wake_pin_n), .pin_n_sync(pin_s)
  );

  lpm_req_filter u_filt (
    .cur(mode), .req_go(req_go), .req_mode(req_mode), .dbg_en(dbg_en),
    .take(take), .target(target)
  );

  lpm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .target(target),
    .lpr_req(lpr_req), .dbg_en(dbg_en), .irq_lines(irq_lines),
    .irq_en(irq_en), .pin_n_sync(pin_s), .ppd_clr(ppd_clr),
    .mode(mode), .ppd_flag(ppd_flag)
  );

  lpm_reg_map u_map (
    .mode(mode), .dbg_en(dbg_en), .rg(rg), .standby(reg_standby)
  );

  assign cur_mode = mode;
  assign reg_ctl  = rg;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_en,
  input logic [N_IRQ-1:0] irq_lines,
  input logic [2:0]       cur_mode,
  input logic [1:0]       reg_ctl,
  input logic             reg_standby,
  input logic             ppd_flag
);
  p_standby_modes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_standby |-> (cur_mode == M_LPRUN || cur_mode == M_LPWAIT ||
                     cur_mode == M_STOP3));

  p_run_exit_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode) == M_RUN && cur_mode != M_RUN) |->
      (cur_mode == M_WAIT || cur_mode == M_STOP4 || cur_mode == M_STOP2 ||
       cur_mode == M_LPRUN));

  p_stop2_irq_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_STOP2) |=> (cur_mode == M_STOP2 || cur_mode == M_RUN));

  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ppd_flag) |-> ($past(cur_mode) == M_STOP2 && cur_mode == M_RUN));

  p_dbg_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |-> (reg_ctl == 2'd0 && !reg_standby));

  p_dbg_leave_lprun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_LPRUN && dbg_en) |=> (cur_mode == M_RUN));

  p_stop4_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_mode) == M_STOP4) |-> !$rose(ppd_flag));

  p_irq_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_WAIT && |irq_lines) |=> (cur_mode == M_RUN));
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .irq_lines(irq_lines),
  .cur_mode(cur_mode), .reg_ctl(reg_ctl), .reg_standby(reg_standby),
  .ppd_flag(ppd_flag)
);

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_go = 1'b0;
  logic [2:0]       req_mode = 3'd0;
  logic             lpr_req = 1'b0;
  logic             dbg_en = 1'b0;
  logic [N_IRQ-1:0] irq_lines = '0;
  logic             irq_en = 1'b0;
  logic             wake_pin_n = 1'b1;
  logic             ppd_clr = 1'b0;
  logic [2:0]       cur_mode;
  logic [1:0]       reg_ctl;
  logic             reg_standby;
  logic             ppd_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mode = 0;
  bit m_s1 = 1, m_s2 = 1, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer #(.N_IRQ(N_IRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_mode(req_mode),
    .lpr_req(lpr_req), .dbg_en(dbg_en), .irq_lines(irq_lines),
    .irq_en(irq_en), .wake_pin_n(wake_pin_n), .ppd_clr(ppd_clr),
    .cur_mode(cur_mode), .reg_ctl(reg_ctl), .reg_standby(reg_standby),
    .ppd_flag(ppd_flag)
  );

  function automatic int exp_reg(int m, bit dbg);
    if (dbg) return 0;
    if (m == 3 || m == 4 || m == 5) return 1;
    if (m == 6) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit old_s2;
    bit wake;
    int er;
    old_s2 = m_s2;
    m_s2 = m_s1;
    m_s1 = wake_pin_n;
    wake = (|irq_lines) || (irq_en && !old_s2);
    case (m_mode)
      0: begin
        if (req_go && (req_mode == 1 || req_mode == 2 || req_mode == 6))
          m_mode = (req_mode == 6 && dbg_en) ? 2 : int'(req_mode);
        else if (!dbg_en && lpr_req) m_mode = 3;
      end
      3: begin
        if (dbg_en) m_mode = 0;
        else if (req_go && (req_mode == 4 || req_mode == 5)) m_mode = int'(req_mode);
        else if (!lpr_req) m_mode = 0;
      end
      1, 2: if (wake) m_mode = 0;
      4, 5: if (wake) m_mode = 3;
      6: if (!old_s2) begin m_mode = 0; m_flag = 1; er = 1; end
      default: m_mode = 0;
    endcase
    if (er != 1 && ppd_clr) m_flag = 0;
  endtask

  task automatic compare(string tag);
    chk(tag, int'(cur_mode), m_mode, "mode");
    chk(tag, int'(reg_ctl), exp_reg(m_mode, dbg_en), "reg_ctl");
    chk(tag, int'(reg_standby), exp_reg(m_mode, dbg_en) == 1 ? 1 : 0, "standby");
    chk(tag, int'(ppd_flag), int'(m_flag), "flag");
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    req_go = 0;
    ppd_clr = 0;
  endtask

  task automatic request(int m, string tag);
    req_go = 1;
    req_mode = 3'(m);
    tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("R1");
    chk("R1", int'(cur_mode), 0, "reset mode");
    rst_n = 1;
    tick("R1");

    // R3: illegal LPwait from Run is ignored
    request(4, "R3");
    chk("R3", int'(cur_mode), 0, "illegal ignored");
    // R3/R2: enter LPrun via regulator request, standby status
    lpr_req = 1;
    tick("R3");
    chk("R2", int'(reg_ctl), 1, "lprun standby code");
    chk("R2", int'(reg_standby), 1, "lprun standby bit");
    // R4: Stop3 from LPrun, irq returns to LPrun
    request(5, "R3");
    chk("R3", int'(cur_mode), 5, "stop3 entered");
    irq_lines = 8'h10;
    tick("R4");
    irq_lines = '0;
    chk("R4", int'(cur_mode), 3, "stop3 back to lprun");
    lpr_req = 0;
    tick("R3");
    chk("R3", int'(cur_mode), 0, "lprun back to run");

    // R5: pin does not wake Stop4 while irq_en is 0
    request(2, "R5");
    wake_pin_n = 0;
    irq_en = 0;
    repeat (4) tick("R5");
    chk("R5", int'(cur_mode), 2, "stop4 held with irq_en 0");
    irq_en = 1;
    tick("R5");
    chk("R5", int'(cur_mode), 0, "stop4 woken by pin");
    wake_pin_n = 1;
    irq_en = 0;
    repeat (3) tick("R5");

    // R6: Stop2 ignores irq lines, pin exit latency of three edges
    request(6, "R6");
    chk("R2", int'(reg_ctl), 2, "stop2 partial off");
    irq_lines = 8'hff;
    repeat (3) tick("R6");
    chk("R6", int'(cur_mode), 6, "stop2 ignores irq");
    irq_lines = '0;
    wake_pin_n = 0;
    tick("R6");
    tick("R6");
    chk("R6", int'(cur_mode), 6, "still stop2 after two edges");
    ppd_clr = 1;
    tick("R7");
    chk("R6", int'(cur_mode), 0, "stop2 exit at third edge");
    chk("R7", int'(ppd_flag), 1, "set wins over clear");
    wake_pin_n = 1;
    repeat (2) tick("R7");
    chk("R7", int'(ppd_flag), 1, "flag sticky");
    ppd_clr = 1;
    tick("R7");
    chk("R7", int'(ppd_flag), 0, "flag cleared");

    // R8/R9: debug remaps Stop2 to Stop4, wake leaves flag clear
    dbg_en = 1;
    lpr_req = 1;
    tick("R8");
    chk("R8", int'(cur_mode), 0, "lpr ignored in debug");
    chk("R8", int'(reg_standby), 0, "standby reads 0");
    request(6, "R8");
    chk("R8", int'(cur_mode), 2, "stop2 replaced by stop4");
    wake_pin_n = 0;
    irq_en = 1;
    repeat (3) tick("R9");
    chk("R9", int'(cur_mode), 0, "forced stop4 woke");
    chk("R9", int'(ppd_flag), 0, "no recovery flag");
    wake_pin_n = 1;
    dbg_en = 0;
    lpr_req = 0;
    repeat (3) tick("R8");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      req_go     = ($urandom_range(0, 4) == 0);
      req_mode   = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) lpr_req = ~lpr_req;
      if ($urandom_range(0, 59) == 0) dbg_en = ~dbg_en;
      irq_lines  = ($urandom_range(0, 15) == 0) ? N_IRQ'($urandom) : '0;
      irq_en     = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 11) == 0) wake_pin_n = ~wake_pin_n;
      ppd_clr    = ($urandom_range(0, 15) == 0);
      tick("R3");
    end
    finish_run();
  end
endmodule